// File: doc/BRIEF.md
# Shifted-Register OR-NOT Execute Unit

This unit takes one 32-bit instruction word per clock and runs it against a small general-purpose register file. The instruction form is a logical OR-with-complement whose second operand is shifted. The unit first splits the word into its fields and confirms that the fixed bits name this operation. It then reads two source registers and shifts the second one by one of four shift kinds. It forms the first source ORed with the complement of the shifted value and writes the result back at 32-bit or 64-bit width. The unit has no condition flags.

A caller presents a word together with a valid strobe. On the next clock edge the unit raises a done pulse and reports one outcome. The word may not belong to this operation. It may be an undefined encoding, in which case nothing is written. Otherwise the result is written back, and the destination index and data are shown on the write-back port. A write is visible to an instruction presented in the very next cycle.

Top module: `orn_exec_unit`

## Requirements
- R1: A word matches only when bits 30:29 are 01, bits 28:24 are 01010 and bit 21 is 1. A valid word that does not match raises `nomatch` with `done`, writes no register and keeps `wb_en` low.
- R2: A matching word with bit 31 equal to 0 and bit 15 equal to 1 is undefined. It raises `undef` with `done`, writes no register and keeps `wb_en` low.
- R3: Bit 31 selects the operating width: 0 gives 32 bits and 1 gives 64 bits.
- R4: Bits 23:22 select the shift applied to the second operand: 00 logical left, 01 logical right, 10 arithmetic right (sign taken from the top bit of the active width), 11 rotate right within the active width.
- R5: The shift amount is the unsigned value of bits 15:10. It spans 0 to 63 at 64-bit width and 0 to 31 at 32-bit width.
- R6: The result is reg[bits 9:5] OR NOT(shifted reg[bits 20:16]). It is written to reg[bits 4:0] and shown on `wb_data` with `wb_idx` equal to bits 4:0.
- R7: At 32-bit width only the low 32 bits of both sources are used, and bits 63:32 of the written result are zero.
- R8: Register index 31 reads as zero, and a write to index 31 is discarded.
- R9: After reset, registers 0 to 30 hold zero, and `done`, `wb_en`, `undef` and `nomatch` are low.
- R10: `done` is high for exactly the one cycle after each cycle with `insn_valid` high. `wb_en`, `wb_idx`, `wb_data`, `undef` and `nomatch` are valid in that same cycle, and a written register is seen by the instruction presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Strobe: insn_word is to be executed |
| insn_word | input | 32 | Instruction word |
| done | output | 1 | One-cycle pulse for each accepted word |
| undef | output | 1 | Word was an undefined encoding |
| nomatch | output | 1 | Word is not this operation |
| wb_en | output | 1 | A result was written back |
| wb_idx | output | 5 | Destination index of the write-back |
| wb_data | output | 64 | Result value written back |

## Verification
Every result appears in the cycle after the clock edge that sampled `insn_valid`. The bench drives a word on a falling edge and compares all outputs on the next falling edge. By then exactly one rising edge, through the single output register stage, has passed. Its reference model updates its own register copy at the same point. Back-to-back words therefore check that a write is seen one cycle later. Cycles with `insn_valid` low are compared in the same way, and `done` and `wb_en` must be low in them.

// File: rtl/orn_pkg.sv
package orn_pkg;

   typedef enum logic [1:0] {
      SHK_LSL = 2'b00,
      SHK_LSR = 2'b01,
      SHK_ASR = 2'b10,
      SHK_ROR = 2'b11
   } shift_kind_e;

   typedef struct packed {
      logic        match;
      logic        undef;
      logic        wide;
      shift_kind_e kind;
      logic [5:0]  amount;
      logic [4:0]  src_a;
      logic [4:0]  src_b;
      logic [4:0]  dst;
   } orn_fields_t;

   localparam logic [1:0] OPC_ORR_FAMILY = 2'b01;
   localparam logic [4:0] FIXED_LOGICAL  = 5'b01010;

endpackage

// File: rtl/orn_decode.sv
module orn_decode
   import orn_pkg::*;
(
   input  logic [31:0] word,
   output orn_fields_t fields
);

   logic fixed_ok;

   always_comb begin
      fixed_ok      = (word[30:29] == OPC_ORR_FAMILY) &&
                      (word[28:24] == FIXED_LOGICAL) && word[21];
      fields.match  = fixed_ok;
      fields.undef  = fixed_ok && !word[31] && word[15];
      fields.wide   = word[31];
      fields.kind   = shift_kind_e'(word[23:22]);
      fields.amount = word[15:10];
      fields.src_b  = word[20:16];
      fields.src_a  = word[9:5];
      fields.dst    = word[4:0];
   end

endmodule

// File: rtl/orn_shifter.sv
module orn_shifter
   import orn_pkg::*;
#(
   parameter int W = 64,
   localparam int AW = $clog2(W)
)(
   input  logic [W-1:0]  val,
   input  shift_kind_e   kind,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  res
);

   logic [2*W-1:0] doubled;

   always_comb begin
      doubled = {val, val} >> amt;
      unique case (kind)
         SHK_LSL: res = val << amt;
         SHK_LSR: res = val >> amt;
         SHK_ASR: res = W'($signed(val) >>> amt);
         default: res = doubled[W-1:0];
      endcase
   end

endmodule

// File: rtl/orn_regfile.sv
module orn_regfile #(
   parameter int XLEN = 64,
   parameter int NREG = 32,
   localparam int IW      = $clog2(NREG),
   localparam int ZERO_IX = NREG - 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IW-1:0]   rd_a_idx,
   input  logic [IW-1:0]   rd_b_idx,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b,
   input  logic            we,
   input  logic [IW-1:0]   wr_idx,
   input  logic [XLEN-1:0] wr_data
);

   logic [XLEN-1:0] regs [ZERO_IX];

   for (genvar g = 0; g < ZERO_IX; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (we && wr_idx == IW'(g))
            regs[g] <= wr_data;
      end
   end

   always_comb begin
      rd_a = (rd_a_idx == IW'(ZERO_IX)) ? '0 : regs[rd_a_idx];
      rd_b = (rd_b_idx == IW'(ZERO_IX)) ? '0 : regs[rd_b_idx];
   end

endmodule

// File: rtl/orn_exec_unit.sv
module orn_exec_unit
   import orn_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int NREG = 32,
   localparam int HLEN = XLEN / 2,
   localparam int IW   = $clog2(NREG)
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        insn_valid,
   input  logic [31:0] insn_word,
   output logic        done,
   output logic        undef,
   output logic        nomatch,
   output logic        wb_en,
   output logic [4:0]  wb_idx,
   output logic [63:0] wb_data
);

   if (XLEN != 64) begin : g_bad_xlen
      $error("orn_exec_unit: XLEN must be 64");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("orn_exec_unit: NREG must be 32");
   end

   orn_fields_t f;
   logic [XLEN-1:0] op_a, op_b, sh_wide, result;
   logic [HLEN-1:0] sh_narrow;
   logic            do_write;

   orn_decode dec_i (
      .word   (insn_word),
      .fields (f)
   );

   orn_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (f.src_a),
      .rd_b_idx (f.src_b),
      .rd_a     (op_a),
      .rd_b     (op_b),
      .we       (do_write),
      .wr_idx   (f.dst),
      .wr_data  (result)
   );

   for (genvar w = 0; w < 2; w++) begin : g_width
      if (w == 0) begin : g_narrow
         orn_shifter #(.W(HLEN)) sh_i (
            .val  (op_b[HLEN-1:0]),
            .kind (f.kind),
            .amt  (f.amount[$clog2(HLEN)-1:0]),
            .res  (sh_narrow)
         );
      end else begin : g_wide
         orn_shifter #(.W(XLEN)) sh_i (
            .val  (op_b),
            .kind (f.kind),
            .amt  (f.amount[$clog2(XLEN)-1:0]),
            .res  (sh_wide)
         );
      end
   end

   always_comb begin
      if (f.wide)
         result = op_a | ~sh_wide;
      else
         result = {{HLEN{1'b0}}, op_a[HLEN-1:0] | ~sh_narrow};
      do_write = insn_valid && f.match && !f.undef;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done    <= 1'b0;
         undef   <= 1'b0;
         nomatch <= 1'b0;
         wb_en   <= 1'b0;
         wb_idx  <= '0;
         wb_data <= '0;
      end else begin
         done    <= insn_valid;
         undef   <= insn_valid && f.undef;
         nomatch <= insn_valid && !f.match;
         wb_en   <= do_write;
         if (insn_valid) begin
            wb_idx  <= f.dst;
            wb_data <= result;
         end
      end
   end

endmodule

// File: rtl/orn_exec_chk.sv
module orn_exec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        insn_valid,
   input logic [31:0] insn_word,
   input logic        done,
   input logic        undef,
   input logic        nomatch,
   input logic        wb_en,
   input logic [4:0]  wb_idx,
   input logic [63:0] wb_data
);

   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R10: a strobe is answered by done on the next edge
   assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |=> done);

   // R10: done only after a strobe
   assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && done) |-> $past(insn_valid));

   // R2: undefined encodings write nothing
   assert_undef_nowb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (!wb_en && done));

   // R1: non-matching words write nothing and are not undefined
   assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      nomatch |-> (!wb_en && !undef && done));

   // R7: narrow results have a zero upper half
   assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && wb_en && !$past(insn_word[31])) |-> (wb_data[63:32] == 32'h0));

   // R6: write-back index is the destination field
   assert_wb_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && wb_en) |-> (wb_idx == $past(insn_word[4:0])));

endmodule

bind orn_exec_unit orn_exec_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn_word  (insn_word),
   .done       (done),
   .undef      (undef),
   .nomatch    (nomatch),
   .wb_en      (wb_en),
   .wb_idx     (wb_idx),
   .wb_data    (wb_data)
);

// File: tb/orn_exec_unit_tb_top.sv
module orn_exec_unit_tb_top;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn_word = '0;
   logic        done, undef, nomatch, wb_en;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;

   int checks = 0;
   int fails  = 0;
   logic [63:0] model [31];

   always #(CLK_PERIOD/2) clk = ~clk;

   orn_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
      .done(done), .undef(undef), .nomatch(nomatch), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data)
   );

   function automatic logic [31:0] enc(input bit sf, input logic [1:0] opc,
                                       input logic [1:0] sh, input bit n,
                                       input int rm, input int amt,
                                       input int rn, input int rd);
      return {sf, opc, 5'b01010, sh, n, 5'(rm), 6'(amt), 5'(rn), 5'(rd)};
   endfunction

   function automatic logic [63:0] rdreg(input int i);
      return (i == 31) ? 64'h0 : model[i];
   endfunction

   function automatic logic [63:0] ref_calc(input bit sf, input logic [1:0] sh,
                                            input int amt, input logic [63:0] a,
                                            input logic [63:0] b);
      logic [63:0] s;
      logic [31:0] b32, s32;
      if (sf) begin
         case (sh)
            2'b00: s = b << amt;
            2'b01: s = b >> amt;
            2'b10: for (int i = 0; i < 64; i++) s[i] = (i + amt > 63) ? b[63] : b[i+amt];
            default: for (int i = 0; i < 64; i++) s[i] = b[(i + amt) % 64];
         endcase
         return a | ~s;
      end
      b32 = b[31:0];
      case (sh)
         2'b00: s32 = b32 << amt;
         2'b01: s32 = b32 >> amt;
         2'b10: for (int i = 0; i < 32; i++) s32[i] = (i + amt > 31) ? b32[31] : b32[i+amt];
         default: for (int i = 0; i < 32; i++) s32[i] = b32[(i + amt) % 32];
      endcase
      return {32'h0, a[31:0] | ~s32};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; checks on the next falling edge
   task automatic step(input bit v, input logic [31:0] w, input string tag);
      bit m, e_undef, e_wb;
      logic [63:0] e_data;
      int rd;
      insn_valid = v;
      insn_word  = w;
      m = (w[30:29] == 2'b01) && (w[28:24] == 5'b01010) && w[21];
      e_undef = v && m && !w[31] && w[15];
      e_wb    = v && m && !e_undef;
      rd      = int'(w[4:0]);
      e_data  = ref_calc(w[31], w[23:22], int'(w[15:10]),
                         rdreg(int'(w[9:5])), rdreg(int'(w[20:16])));
      @(negedge clk);
      chk({"R10 done ", tag}, 64'(done), 64'(v));
      chk({"R2 undef ", tag}, 64'(undef), 64'(e_undef));
      chk({"R1 nomatch ", tag}, 64'(nomatch), 64'(v && !m));
      chk({"R1 wb_en ", tag}, 64'(wb_en), 64'(e_wb));
      if (e_wb) begin
         chk({"R6 wb_idx ", tag}, 64'(wb_idx), 64'(rd));
         chk({"R6 wb_data ", tag}, wb_data, e_data);
         if (rd != 31) model[rd] = e_data;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 31; i++) model[i] = 64'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset done", 64'(done), 64'h0);
      chk("R9 reset wb_en", 64'(wb_en), 64'h0);
      chk("R9 reset undef/nomatch", 64'({undef, nomatch}), 64'h0);
      // R9: every register reads zero, so NOT gives all ones
      for (int k = 0; k < 31; k++) step(1, enc(1, 2'b01, 2'b00, 1, k, 0, 31, k), "R9 zero read");
      // build varied values
      step(1, enc(1, 2'b01, 2'b00, 1, 1, 7, 31, 2), "R4 LSL 64");
      step(1, enc(1, 2'b01, 2'b11, 1, 2, 20, 31, 3), "R4 ROR 64");
      step(1, enc(1, 2'b01, 2'b01, 1, 3, 5, 2, 4), "R4 LSR 64");
      step(1, enc(1, 2'b01, 2'b10, 1, 3, 9, 31, 5), "R4 ASR 64");
      step(1, enc(1, 2'b01, 2'b10, 1, 5, 3, 31, 6), "R4 ASR negative");
      // amounts 0 and maximum, both widths, all kinds
      for (int s = 0; s < 4; s++) begin
         step(1, enc(1, 2'b01, 2'(s), 1, 3, 0, 4, 7), "R5 amount 0 64");
         step(1, enc(1, 2'b01, 2'(s), 1, 6, 63, 5, 8), "R5 amount 63 64");
         step(1, enc(0, 2'b01, 2'(s), 1, 3, 0, 4, 9), "R3 R7 amount 0 32");
         step(1, enc(0, 2'b01, 2'(s), 1, 6, 31, 5, 10), "R5 R7 amount 31 32");
      end
      // R8: write to 31 discarded, reads back zero
      step(1, enc(1, 2'b01, 2'b00, 1, 31, 0, 31, 31), "R8 write 31");
      step(1, enc(1, 2'b01, 2'b00, 1, 31, 0, 31, 11), "R8 read 31");
      // R2: undefined narrow with amount bit 5
      step(1, enc(0, 2'b01, 2'b00, 1, 2, 33, 3, 12), "R2 undef");
      step(1, enc(1, 2'b01, 2'b00, 1, 31, 0, 12, 13), "R2 no write to 12");
      // R1: mismatches
      step(1, enc(1, 2'b00, 2'b00, 1, 2, 1, 3, 14), "R1 opc");
      step(1, enc(1, 2'b01, 2'b00, 0, 2, 1, 3, 14), "R1 N bit");
      step(1, {8'hCB, 24'h200000} | 32'h0000_000E, "R1 fixed bits");
      step(1, enc(1, 2'b01, 2'b00, 1, 31, 0, 14, 15), "R1 no write to 14");
      step(0, enc(1, 2'b01, 2'b00, 1, 1, 0, 1, 16), "R10 idle");
      // random back-to-back
      for (int t = 0; t < 4000; t++) begin
         logic [31:0] w;
         w = $urandom;
         if ($urandom % 8 != 0) w = {w[31], 2'b01, 5'b01010, w[23:22], 1'b1, w[20:0]};
         step(($urandom % 5) != 0, w, "R6 random");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule